// File: doc/BRIEF.md
# DC/DC Soft-Start Stage Sequencer

This block runs the soft-start ramp of a display controller's DC/DC converter. The ramp is described by a parameter table of four 8-byte stage records. After a `start` pulse, the sequencer fetches each record in turn through a synchronous read port with one cycle of latency. It then decodes the repeat count, the two starting phase values, the two signed per-iteration increments, the two switch settings and the end-of-iteration delay. The table storage sits outside the block.

Each iteration produces three register writes on a command port: the switch register with the start setting, then the phase register with both accumulated phase bytes, then the switch register with the end setting. A millisecond wait follows each iteration. The serial engine that carries the writes sits behind a valid/ready handshake. A record with a cleared format or scale bit stops the run before that stage writes anything and raises an error flag.

Top module: `softstart_seq`

## Requirements
- R1: While reset is held and after its release, `cmd_valid`, `run`, `done` and `err` are all 0 until a `start` pulse arrives.
- R2: Stage s (s = 0..3) is read from table addresses 0x28+8*s to 0x2F+8*s. `tbl_rdata` carries the byte of the address presented one cycle earlier. The stages run in ascending order.
- R3: Each iteration issues exactly three writes in this order: code 0x09 with length 1 and data byte 0 = record byte 5; code 0x51 with length 2, data byte 0 = PHL and data byte 1 = PHH; code 0x09 with length 1 and data byte 0 = record byte 6. The unused data byte of a length-1 write is 0x00.
- R4: PHL and PHH start at record bytes 1 and 2. Record bytes 3 and 4 are added as 8-bit two's-complement values before every phase write, so the first write already carries start+increment. The sums wrap modulo 256.
- R5: Bits 6..0 of record byte 0 give the iteration count. A count of 0 issues no writes for that stage, and the run moves to the next stage.
- R6: After the third write of every iteration, the sequencer waits D*TICKS_PER_MS cycles, where D is bits 6..0 of record byte 7. With `cmd_ready` held high, the next iteration's first write is accepted D*TICKS_PER_MS+2 cycles after the previous write.
- R7: If bit 7 of record byte 0 (format) or bit 7 of record byte 7 (scale) is 0, that stage and all later stages issue no writes. `err` goes to 1, `run` drops, and `done` does not pulse. `err` holds until the next `start`, which clears it.
- R8: A write is taken only in a cycle with `cmd_valid` and `cmd_ready` both high. While `cmd_ready` is low, the code, the length and both data bytes hold steady. No write is lost or repeated.
- R9: `run` is high from the cycle after an accepted `start` until the run ends. A successful run ends with a one-cycle `done` pulse in the same cycle `run` falls. `start` has no effect while `run` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a soft-start run (ignored while running) |
| tbl_addr | output | 8 | Parameter table read address |
| tbl_rdata | input | 8 | Table byte for the address of the previous cycle |
| cmd_valid | output | 1 | Register write pending |
| cmd_ready | input | 1 | Command engine accepts the pending write |
| cmd_code | output | 8 | Register code of the write |
| cmd_len | output | 2 | Number of data bytes (1 or 2) |
| cmd_d0 | output | 8 | First data byte |
| cmd_d1 | output | 8 | Second data byte (0 when the length is 1) |
| run | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | Run aborted on a bad format or scale bit |

## Verification
The assertions assume that `cmd_ready` is a free-running input whose value matters only while `cmd_valid` is high. They also assume that the table answers every address within one cycle, so a record fetch always completes. The bench's memory model answers every address on the next edge. It drives `cmd_ready` either high throughout or in a repeating one-in-three pattern. `start` is pulsed only from idle, except in the one test that checks it is ignored mid-run. Delay timing is compared only in runs where `cmd_ready` stays high, because stalls stretch the gap by design.

// File: rtl/softstart_pkg.sv
package softstart_pkg;

  localparam logic [7:0] REG_SWITCH = 8'h09;
  localparam logic [7:0] REG_PHASE  = 8'h51;
  localparam int         REC_BYTES  = 8;
  localparam int         IDX_W      = $clog2(REC_BYTES);

  typedef struct packed {
    logic       fmt;
    logic [6:0] reps;
    logic [7:0] phl_init;
    logic [7:0] phh_init;
    logic [7:0] phl_step;
    logic [7:0] phh_step;
    logic [7:0] sw_start;
    logic [7:0] sw_end;
    logic       scale;
    logic [6:0] dly_ms;
  } stage_rec_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_SWA, S_ADD, S_PHASE, S_SWB, S_WAIT
  } seq_state_t;

  function automatic stage_rec_t decode_rec(input logic [REC_BYTES-1:0][7:0] b);
    stage_rec_t r;
    r.fmt      = b[0][7];
    r.reps     = b[0][6:0];
    r.phl_init = b[1];
    r.phh_init = b[2];
    r.phl_step = b[3];
    r.phh_step = b[4];
    r.sw_start = b[5];
    r.sw_end   = b[6];
    r.scale    = b[7][7];
    r.dly_ms   = b[7][6:0];
    return r;
  endfunction

endpackage

// File: rtl/ss_rst_sync.sv
module ss_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ss_rec_fetch.sv
module ss_rec_fetch
  import softstart_pkg::*;
#(
  parameter int              ADDR_W = 8,
  parameter int              STG_W  = 2,
  parameter logic [ADDR_W-1:0] BASE = 8'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [STG_W-1:0]  stage_idx,
  output logic [ADDR_W-1:0] addr,
  input  logic [7:0]        rdata,
  output stage_rec_t        rec,
  output logic              rec_done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REC_BYTES - 1);

  logic                       active_q, active_d;
  logic [IDX_W-1:0]           idx_q, idx_d;
  logic [STG_W-1:0]           stg_q, stg_d;
  logic                       pend_q;
  logic [IDX_W-1:0]           pidx_q;
  logic                       done_q, done_d;
  logic [REC_BYTES-1:0][7:0]  bytes_q;

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    stg_d    = stg_q;
    if (req) begin
      active_d = 1'b1;
      idx_d    = '0;
      stg_d    = stage_idx;
    end else if (active_q) begin
      idx_d = idx_q + 1'b1;
      if (idx_q == LAST_IDX) active_d = 1'b0;
    end
    done_d = pend_q && (pidx_q == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      stg_q    <= '0;
      pend_q   <= 1'b0;
      pidx_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
      stg_q    <= stg_d;
      pend_q   <= active_q;
      pidx_q   <= idx_q;
      done_q   <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytes_q <= '0;
    end else if (pend_q) begin
      bytes_q[pidx_q] <= rdata;
    end
  end

  assign addr     = BASE + ADDR_W'({stg_q, idx_q});
  assign rec      = decode_rec(bytes_q);
  assign rec_done = done_q;
endmodule

// File: rtl/ss_ms_timer.sv
module ss_ms_timer #(
  parameter int TICKS_PER_MS = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [6:0] ms,
  output logic       busy
);
  localparam int TW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICKS_PER_MS - 1);

  logic [TW-1:0] tick_q, tick_d;
  logic [6:0]    ms_q, ms_d;

  always_comb begin
    tick_d = tick_q;
    ms_d   = ms_q;
    if (load) begin
      tick_d = '0;
      ms_d   = ms;
    end else if (ms_q != 7'd0) begin
      if (tick_q == TICK_LAST) begin
        tick_d = '0;
        ms_d   = ms_q - 7'd1;
      end else begin
        tick_d = tick_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      ms_q   <= '0;
    end else begin
      tick_q <= tick_d;
      ms_q   <= ms_d;
    end
  end

  assign busy = (ms_q != 7'd0);
endmodule

// File: rtl/ss_phase_acc.sv
module ss_phase_acc #(
  parameter int LANES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  add,
  input  logic [LANES-1:0][7:0] init,
  input  logic [LANES-1:0][7:0] step,
  output logic [LANES-1:0][7:0] value
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] acc_q, acc_d;

    always_comb begin
      acc_d = acc_q;
      if (load)     acc_d = init[g];
      else if (add) acc_d = acc_q + step[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= 8'h00;
      else        acc_q <= acc_d;
    end

    assign value[g] = acc_q;
  end
endmodule

// File: rtl/ss_seq_ctrl.sv
module ss_seq_ctrl
  import softstart_pkg::*;
#(
  parameter int STAGES = 4,
  parameter int STG_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  stage_rec_t       rec,
  input  logic             rec_done,
  input  logic             tmr_busy,
  input  logic [1:0][7:0]  acc_val,
  input  logic             cmd_ready,
  output logic             fetch_req,
  output logic [STG_W-1:0] stage_idx,
  output logic             acc_load,
  output logic             acc_add,
  output logic             tmr_load,
  output logic             cmd_valid,
  output logic [7:0]       cmd_code,
  output logic [1:0]       cmd_len,
  output logic [7:0]       cmd_d0,
  output logic [7:0]       cmd_d1,
  output logic             run,
  output logic             done,
  output logic             err
);
  localparam logic [STG_W-1:0] LAST_STAGE = STG_W'(STAGES - 1);

  seq_state_t       state_q, state_d;
  logic [STG_W-1:0] stage_q, stage_d;
  logic [6:0]       reps_q, reps_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic             advance;

  always_comb begin
    state_d   = state_q;
    stage_d   = stage_q;
    reps_d    = reps_q;
    err_d     = err_q;
    done_d    = 1'b0;
    fetch_req = 1'b0;
    acc_load  = 1'b0;
    acc_add   = 1'b0;
    tmr_load  = 1'b0;
    advance   = 1'b0;

    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          stage_d   = '0;
          err_d     = 1'b0;
          fetch_req = 1'b1;
          state_d   = S_FETCH;
        end
      end
      S_FETCH: begin
        if (rec_done) state_d = S_CHECK;
      end
      S_CHECK: begin
        if (!rec.fmt || !rec.scale) begin
          err_d   = 1'b1;
          state_d = S_IDLE;
        end else if (rec.reps == 7'd0) begin
          advance = 1'b1;
        end else begin
          acc_load = 1'b1;
          reps_d   = rec.reps;
          state_d  = S_SWA;
        end
      end
      S_SWA: begin
        if (cmd_ready) state_d = S_ADD;
      end
      S_ADD: begin
        acc_add = 1'b1;
        state_d = S_PHASE;
      end
      S_PHASE: begin
        if (cmd_ready) state_d = S_SWB;
      end
      S_SWB: begin
        if (cmd_ready) begin
          tmr_load = 1'b1;
          state_d  = S_WAIT;
        end
      end
      S_WAIT: begin
        if (!tmr_busy) begin
          if (reps_q == 7'd1) begin
            advance = 1'b1;
          end else begin
            reps_d  = reps_q - 7'd1;
            state_d = S_SWA;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase

    if (advance) begin
      if (stage_q == LAST_STAGE) begin
        state_d = S_IDLE;
        done_d  = 1'b1;
      end else begin
        stage_d   = stage_q + 1'b1;
        fetch_req = 1'b1;
        state_d   = S_FETCH;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      stage_q <= '0;
      reps_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      stage_q <= stage_d;
      reps_q  <= reps_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_comb begin
    cmd_valid = 1'b0;
    cmd_code  = 8'h00;
    cmd_len   = 2'd0;
    cmd_d0    = 8'h00;
    cmd_d1    = 8'h00;
    unique case (state_q)
      S_SWA: begin
        cmd_valid = 1'b1;
        cmd_code  = REG_SWITCH;
        cmd_len   = 2'd1;
        cmd_d0    = rec.sw_start;
      end
      S_PHASE: begin
        cmd_valid = 1'b1;
        cmd_code  = REG_PHASE;
        cmd_len   = 2'd2;
        cmd_d0    = acc_val[0];
        cmd_d1    = acc_val[1];
      end
      S_SWB: begin
        cmd_valid = 1'b1;
        cmd_code  = REG_SWITCH;
        cmd_len   = 2'd1;
        cmd_d0    = rec.sw_end;
      end
      default: ;
    endcase
  end

  assign stage_idx = stage_d;
  assign run       = (state_q != S_IDLE);
  assign done      = done_q;
  assign err       = err_q;
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import softstart_pkg::*;
#(
  parameter int              TICKS_PER_MS = 50000,
  parameter int              STAGES       = 4,
  parameter int              ADDR_W       = 8,
  parameter logic [ADDR_W-1:0] TABLE_BASE = 8'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] tbl_addr,
  input  logic [7:0]        tbl_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [7:0]        cmd_code,
  output logic [1:0]        cmd_len,
  output logic [7:0]        cmd_d0,
  output logic [7:0]        cmd_d1,
  output logic              run,
  output logic              done,
  output logic              err
);
  localparam int STG_W = (STAGES > 1) ? $clog2(STAGES) : 1;

  logic             rst_n_i;
  logic             fetch_req, rec_done;
  logic [STG_W-1:0] stage_idx;
  stage_rec_t       rec;
  logic             acc_load, acc_add;
  logic [1:0][7:0]  acc_init, acc_step, acc_val;
  logic             tmr_load, tmr_busy;

  ss_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  ss_rec_fetch #(
    .ADDR_W (ADDR_W),
    .STG_W  (STG_W),
    .BASE   (TABLE_BASE)
  ) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .req       (fetch_req),
    .stage_idx (stage_idx),
    .addr      (tbl_addr),
    .rdata     (tbl_rdata),
    .rec       (rec),
    .rec_done  (rec_done)
  );

  assign acc_init = {rec.phh_init, rec.phl_init};
  assign acc_step = {rec.phh_step, rec.phl_step};

  ss_phase_acc #(.LANES(2)) u_acc (
    .clk   (clk),
    .rst_n (rst_n_i),
    .load  (acc_load),
    .add   (acc_add),
    .init  (acc_init),
    .step  (acc_step),
    .value (acc_val)
  );

  ss_ms_timer #(.TICKS_PER_MS(TICKS_PER_MS)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n_i),
    .load  (tmr_load),
    .ms    (rec.dly_ms),
    .busy  (tmr_busy)
  );

  ss_seq_ctrl #(
    .STAGES (STAGES),
    .STG_W  (STG_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .start     (start),
    .rec       (rec),
    .rec_done  (rec_done),
    .tmr_busy  (tmr_busy),
    .acc_val   (acc_val),
    .cmd_ready (cmd_ready),
    .fetch_req (fetch_req),
    .stage_idx (stage_idx),
    .acc_load  (acc_load),
    .acc_add   (acc_add),
    .tmr_load  (tmr_load),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_len   (cmd_len),
    .cmd_d0    (cmd_d0),
    .cmd_d1    (cmd_d1),
    .run       (run),
    .done      (done),
    .err       (err)
  );
endmodule

// File: rtl/softstart_seq_chk.sv
module softstart_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [7:0] cmd_code,
  input logic [1:0] cmd_len,
  input logic [7:0] cmd_d0,
  input logic [7:0] cmd_d1,
  input logic       run,
  input logic       done,
  input logic       err
);
  // R8: a stalled write keeps every field steady
  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_code) && $stable(cmd_len)
                                   && $stable(cmd_d0) && $stable(cmd_d1)));

  // R3: only the two legal write shapes appear, with an unused byte of zero
  a_r3_write_shape: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ((cmd_code == 8'h51 && cmd_len == 2'd2) ||
                   (cmd_code == 8'h09 && cmd_len == 2'd1 && cmd_d1 == 8'h00)));

  // R7: an aborted run issues nothing further
  a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !cmd_valid);

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: a run ends only through done or err
  a_r9_run_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> (done || err));

  // R9: writes only while running
  a_r9_valid_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> run);
endmodule

bind softstart_seq softstart_seq_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_code  (cmd_code),
  .cmd_len   (cmd_len),
  .cmd_d0    (cmd_d0),
  .cmd_d1    (cmd_d1),
  .run       (run),
  .done      (done),
  .err       (err)
);

// File: tb/softstart_seq_tb_top.sv
`timescale 1ns/1ps
module softstart_seq_tb_top;
  localparam int T = 4;
  localparam int NCASE = 6;
  // record pattern bytes b0..b7 (MSB first); stage s gets b1+s and b5^s
  localparam logic [63:0] CASE_PAT [NCASE] = '{
    64'h82_0A_14_01_FB_11_22_81,
    64'h83_F0_05_08_FD_33_44_80,
    64'h80_01_02_03_04_05_06_82,
    64'h01_01_02_03_04_05_06_81,
    64'h81_01_02_03_04_05_06_02,
    64'h85_7F_80_7F_81_55_66_81
  };
  localparam int CASE_WR  [NCASE] = '{24, 36, 0, 0, 0, 60};
  localparam bit CASE_ERR [NCASE] = '{0, 0, 0, 1, 1, 0};

  logic clk, rst_n, start, cmd_ready;
  logic [7:0] tbl_addr, tbl_rdata, cmd_code, cmd_d0, cmd_d1;
  logic [1:0] cmd_len;
  logic cmd_valid, run, done, err;

  softstart_seq #(.TICKS_PER_MS(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .tbl_addr(tbl_addr), .tbl_rdata(tbl_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code), .cmd_len(cmd_len),
    .cmd_d0(cmd_d0), .cmd_d1(cmd_d1), .run(run), .done(done), .err(err)
  );

  logic [7:0] mem [256];
  int  cyc = 0;
  bit  stall_en = 0;
  bit  done_seen;
  int  log_n;
  logic [7:0] log_code [1024], log_d0 [1024], log_d1 [1024];
  logic [1:0] log_len [1024];
  int  log_cyc [1024];
  int  exp_n;
  bit  exp_err;
  logic [7:0] exp_code [1024], exp_d0 [1024], exp_d1 [1024];
  logic [1:0] exp_len [1024];
  int  exp_gap [1024];
  int  n_checks = 0, n_err = 0;

  initial begin clk = 0; forever #4 clk = ~clk; end
  initial forever @(negedge clk) cyc++;
  initial begin tbl_rdata = 8'h00; forever @(posedge clk) tbl_rdata <= mem[tbl_addr]; end
  initial begin
    cmd_ready = 1;
    forever begin
      @(negedge clk);
      cmd_ready = !stall_en || (cyc % 3 == 0);
    end
  end
  initial forever begin
    @(posedge clk);
    if (rst_n && cmd_valid && cmd_ready && log_n < 1024) begin
      log_code[log_n] = cmd_code; log_len[log_n] = cmd_len;
      log_d0[log_n] = cmd_d0; log_d1[log_n] = cmd_d1; log_cyc[log_n] = cyc;
      log_n++;
    end
    if (rst_n && done) done_seen = 1;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic load_pattern(input logic [63:0] p);
    for (int a = 0; a < 256; a++) mem[a] = 8'hEE;
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 8; i++) begin
        logic [7:0] b;
        b = p[63-8*i -: 8];
        if (i == 1) b = b + 8'(s);
        if (i == 5) b = b ^ 8'(s);
        mem[8'h28 + 8*s + i] = b;
      end
  endtask

  // independent model of the requirements (R2..R7)
  task automatic build_expect();
    exp_n = 0; exp_err = 0;
    for (int s = 0; s < 4; s++) begin
      logic [7:0] b [8];
      logic [7:0] pl, ph;
      for (int i = 0; i < 8; i++) b[i] = mem[8'h28 + 8*s + i];
      if (!b[0][7] || !b[7][7]) begin exp_err = 1; break; end
      pl = b[1]; ph = b[2];
      for (int k = 0; k < int'(b[0][6:0]); k++) begin
        pl = pl + b[3]; ph = ph + b[4];
        exp_code[exp_n] = 8'h09; exp_len[exp_n] = 1; exp_d0[exp_n] = b[5]; exp_d1[exp_n] = 0;
        exp_gap[exp_n] = (k > 0) ? int'(b[7][6:0]) * T + 2 : -1; exp_n++;
        exp_code[exp_n] = 8'h51; exp_len[exp_n] = 2; exp_d0[exp_n] = pl; exp_d1[exp_n] = ph;
        exp_gap[exp_n] = -1; exp_n++;
        exp_code[exp_n] = 8'h09; exp_len[exp_n] = 1; exp_d0[exp_n] = b[6]; exp_d1[exp_n] = 0;
        exp_gap[exp_n] = -1; exp_n++;
      end
    end
  endtask

  task automatic run_seq(input bit poke_mid);
    int guard;
    @(negedge clk);
    log_n = 0; done_seen = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    guard = 0;
    while (run && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (poke_mid && guard == 30) start = 1;
      else start = 0;
    end
    start = 0;
    check(guard < 20000, "R9", "run ended", guard, 20000);
    repeat (3) @(negedge clk);
  endtask

  task automatic compare(input string tag, input int wr, input bit e, input bit gaps);
    int bad;
    build_expect();
    check(log_n == wr, "R5", {tag, " write count"}, log_n, wr);
    check(exp_n == wr, "R5", {tag, " model count"}, exp_n, wr);
    bad = -1;
    for (int i = 0; i < log_n && i < exp_n; i++)
      if (bad < 0 && (log_code[i] !== exp_code[i] || log_len[i] !== exp_len[i] ||
                      log_d0[i] !== exp_d0[i] || log_d1[i] !== exp_d1[i])) bad = i;
    if (bad >= 0)
      check(0, "R3/R4", {tag, " write content code,d0,d1 at index"},
            int'({log_code[bad], log_d0[bad], log_d1[bad]}),
            int'({exp_code[bad], exp_d0[bad], exp_d1[bad]}));
    else check(1, "R3", tag, 0, 0);
    if (gaps) begin
      bad = -1;
      for (int i = 1; i < log_n && i < exp_n; i++)
        if (bad < 0 && exp_gap[i] >= 0 && (log_cyc[i] - log_cyc[i-1]) != exp_gap[i]) bad = i;
      if (bad >= 0) check(0, "R6", {tag, " delay gap"}, log_cyc[bad] - log_cyc[bad-1], exp_gap[bad]);
      else check(1, "R6", tag, 0, 0);
    end
    check(err == e, "R7", {tag, " err flag"}, int'(err), int'(e));
    check(done_seen == !e, "R9", {tag, " done pulse"}, int'(done_seen), int'(!e));
  endtask

  initial begin
    #(200000 * 8);
    n_err++; n_checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    start = 0; rst_n = 0; log_n = 0; done_seen = 0;
    load_pattern(CASE_PAT[0]);
    repeat (3) @(negedge clk);
    check(!cmd_valid && !run && !done && !err, "R1", "outputs in reset",
          int'({cmd_valid, run, done, err}), 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check(!cmd_valid && !run && !done && !err, "R1", "outputs after reset",
          int'({cmd_valid, run, done, err}), 0);

    // table walk: R2..R7, R9
    for (int c = 0; c < NCASE; c++) begin
      load_pattern(CASE_PAT[c]);
      run_seq(0);
      compare($sformatf("case%0d", c), CASE_WR[c], CASE_ERR[c], 1);
    end

    // R7: stage 2 has a bad format bit; stages 0 and 1 still run
    load_pattern(CASE_PAT[0]);
    mem[8'h38] = 8'h02;
    run_seq(0);
    compare("R7 late abort", 12, 1, 1);

    // R7: a fresh start clears err
    load_pattern(CASE_PAT[0]);
    run_seq(0);
    compare("R7 err clear", 24, 0, 1);

    // R5: only stage 1 has a zero count
    load_pattern(CASE_PAT[0]);
    mem[8'h30] = 8'h80;
    run_seq(0);
    compare("R5 skip stage1", 18, 0, 1);

    // R8: stalled handshake, no loss or repeat
    stall_en = 1;
    load_pattern(CASE_PAT[5]);
    run_seq(0);
    compare("R8 stall", 60, 0, 0);
    stall_en = 0;

    // R9: start during a run has no effect
    load_pattern(CASE_PAT[1]);
    run_seq(1);
    compare("R9 start ignored", 36, 0, 1);
    check(!run, "R9", "idle after run", int'(run), 0);

    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule